// File: doc/BRIEF.md
# Otsu Automatic Threshold Engine

This block receives one grayscale frame as a stream of 8-bit pixels and returns the global threshold that best separates the frame into a dark class and a bright class. Pixels arrive on a valid/ready stream with an end-of-frame flag. Each beat carries `LANES` pixels, and `LANES` may be 1 or 8. In 8-pixel mode every beat is full, so the frame width must be a multiple of 8. While the frame streams in, each lane counts intensities into its own 256-bin histogram. At the same time the engine keeps a running pixel count `N` and a running intensity sum `S`.

After the last beat the engine closes the input. It walks the 256 bins in ascending order, merging the lanes' bins as it goes. For each candidate level `t`, class 0 holds the pixels with value `<= t` and class 1 holds the rest. Let `c(t)` be the number of pixels in class 0 and `s(t)` their intensity sum. The candidate's between-class score is `(S*c - N*s)^2 / (c*(N-c))`. The engine compares scores by cross-multiplying, so it has no divider. The winning level is presented on `thr_value` together with a one-cycle `thr_valid` pulse. The same walk also zeroes every bin, so the next frame can follow at once.

After reset the engine spends 256 cycles zeroing its histograms, with `in_ready` low, before it accepts pixels.

Top module: `otsu_thresh_engine`

## Requirements
- R1: After reset `thr_valid` is 0 and `in_ready` stays 0 while the 256 bins are zeroed. After that, `in_ready` is 1.
- R2: A beat is taken when `in_valid` and `in_ready` are both 1. Lane k sits in bits `[8k+7:8k]` of `in_data`. Every lane of every beat holds a real pixel.
- R3: From the edge that takes a beat with `in_last` = 1 until the result appears, `in_ready` is 0. `thr_valid` is 1 for exactly one cycle, and `in_ready` is 1 again in that cycle.
- R4: `thr_value` is the level `t` that maximises `(S*c(t) - N*s(t))^2 / (c(t)*(N-c(t)))`, where class 0 is the pixels with value `<= t`.
- R5: Candidates where either class would be empty (`c(t)` = 0 or `c(t)` = N) are not scored.
- R6: When several candidates share the highest score, the lowest level wins.
- R7: If every pixel of the frame has the same gray level, `thr_value` is that level.
- R8: The histogram is cleared without any outside action, so each frame's result depends only on that frame's pixels.
- R9: With 8 lanes, equal values inside one beat and the same value in back-to-back beats are each counted once per pixel.
- R10: The same behaviour holds with `LANES` = 1, where one pixel is taken per beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel beat present |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| in_data | input | LANES*8 | Pixels, lane 0 in the low byte |
| in_last | input | 1 | Beat is the last of the frame |
| thr_valid | output | 1 | One-cycle pulse: threshold is valid |
| thr_value | output | 8 | Selected threshold level |

## Verification
The bench builds two instances side by side. One uses `LANES` = 8, which reaches the per-lane banks, equal values colliding inside a beat, and back-to-back repeats through the increment forwarding path. The other uses `LANES` = 1, which exercises the one-pixel-per-beat handshake over a long series of accepted beats. Both keep the default 21-bit count width. Frames are at most 64 pixels, so the bench model can score every candidate exactly in 64-bit integers, including the tie, single-level and two-adjacent-level cases.

// File: rtl/otsu_pkg.sv
package otsu_pkg;
  localparam int PIX_W  = 8;
  localparam int NBINS  = 256;
  localparam int BIN_AW = 8;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_ACCUM,
    ST_DRAIN,
    ST_SWEEP,
    ST_FLUSH
  } eng_state_e;
endpackage

// File: rtl/otsu_hist_ram.sv
module otsu_hist_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 21
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read, read-before-write on collision
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/otsu_hist_lane.sv
module otsu_hist_lane #(
  parameter int CNT_W = 21
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_valid,
  input  logic [otsu_pkg::PIX_W-1:0] pix,
  input  logic                       sweep_en,
  input  logic [otsu_pkg::BIN_AW-1:0] sweep_addr,
  output logic [CNT_W-1:0]           bin_q
);
  import otsu_pkg::*;

  logic [BIN_AW-1:0] a1, a2, ra, wa;
  logic              v1, v2, we;
  logic [CNT_W-1:0]  w2, rq, newv, wd;

  otsu_hist_ram #(.DEPTH(NBINS), .AW(BIN_AW), .DW(CNT_W)) u_ram (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .ra(ra), .rq(rq)
  );

  assign ra = sweep_en ? sweep_addr : pix;

  // forward the value written last cycle when the same bin is hit again
  always_comb begin
    newv = ((v2 && (a2 == a1)) ? w2 : rq) + CNT_W'(1);
    we   = sweep_en | v1;
    wa   = sweep_en ? sweep_addr : a1;
    wd   = sweep_en ? '0 : newv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      a1 <= '0;
      a2 <= '0;
      w2 <= '0;
    end else begin
      v1 <= pix_valid & ~sweep_en;
      a1 <= pix;
      v2 <= v1 & ~sweep_en;
      a2 <= a1;
      w2 <= newv;
    end
  end

  assign bin_q = rq;

  // R8: zeroing never overlaps a pending increment
  clear_collision_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_en |-> !v1);
endmodule

// File: rtl/otsu_score_sweep.sv
module otsu_score_sweep #(
  parameter int CNT_W = 21,
  parameter int SUM_W = 29
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        hv,
  input  logic [CNT_W-1:0]            hcnt,
  input  logic [otsu_pkg::BIN_AW-1:0] ht,
  input  logic                        hlast,
  input  logic [CNT_W-1:0]            n_tot,
  input  logic [SUM_W-1:0]            m_tot,
  output logic                        res_valid,
  output logic [otsu_pkg::BIN_AW-1:0] res_thr
);
  import otsu_pkg::*;

  localparam int PW = SUM_W + CNT_W;
  localparam int NW = 2 * PW;
  localparam int DW = 2 * CNT_W;
  localparam int XW = NW + DW;

  // stage 2: cumulative count and weighted sum
  logic [CNT_W-1:0]  w0;
  logic [SUM_W-1:0]  m0, wsum;
  logic [BIN_AW-1:0] t2, lvl;
  logic              v2, last2, seen;

  assign wsum = SUM_W'(hcnt) * SUM_W'(ht);

  always_ff @(posedge clk) begin
    if (rst) begin
      w0 <= '0; m0 <= '0; seen <= 1'b0; lvl <= '0;
      v2 <= 1'b0; last2 <= 1'b0; t2 <= '0;
    end else begin
      v2    <= hv & ~start;
      last2 <= hv & hlast & ~start;
      t2    <= ht;
      if (start) begin
        w0 <= '0; m0 <= '0; seen <= 1'b0;
      end else if (hv) begin
        w0 <= w0 + hcnt;
        m0 <= m0 + wsum;
        if (!seen && (hcnt != '0)) begin
          seen <= 1'b1;
          lvl  <= ht;
        end
      end
    end
  end

  // stage 3: numerator and denominator of the score
  logic [PW-1:0]     pa, pb, dif;
  logic [NW-1:0]     num_c, num3;
  logic [DW-1:0]     den_c, den3;
  logic [BIN_AW-1:0] t3;
  logic              v3, last3, ok3;

  always_comb begin
    pa    = PW'(m_tot) * PW'(w0);
    pb    = PW'(n_tot) * PW'(m0);
    dif   = (pa >= pb) ? (pa - pb) : (pb - pa);
    num_c = NW'(dif) * NW'(dif);
    den_c = DW'(w0) * DW'(n_tot - w0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= 1'b0; last3 <= 1'b0; ok3 <= 1'b0;
      num3 <= '0; den3 <= '0; t3 <= '0;
    end else begin
      v3    <= v2;
      last3 <= last2;
      ok3   <= v2 && (w0 != '0) && (w0 != n_tot);
      num3  <= num_c;
      den3  <= den_c;
      t3    <= t2;
    end
  end

  // stage 4: keep the best by cross-multiplication, strict win keeps lowest t
  logic [NW-1:0]     best_num;
  logic [DW-1:0]     best_den;
  logic [BIN_AW-1:0] best_t;
  logic              found, better;
  logic [XW-1:0]     lhs, rhs;

  always_comb begin
    lhs    = XW'(num3) * XW'(best_den);
    rhs    = XW'(best_num) * XW'(den3);
    better = v3 && ok3 && (!found || (lhs > rhs));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      found <= 1'b0; best_num <= '0; best_den <= '0; best_t <= '0;
      res_valid <= 1'b0; res_thr <= '0;
    end else begin
      if (start) begin
        found <= 1'b0;
      end else if (better) begin
        found    <= 1'b1;
        best_num <= num3;
        best_den <= den3;
        best_t   <= t3;
      end
      res_valid <= v3 & last3;
      if (v3 && last3)
        res_thr <= better ? t3 : (found ? best_t : lvl);
    end
  end

  // R4: cumulative class-0 count never decreases across a walk
  w0_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (v2 && $past(v2)) |-> (w0 >= $past(w0)));

  // R8: all banks together hold exactly the frame's pixel count
  bins_total_chk: assert property (@(posedge clk) disable iff (rst)
    (v2 && last2) |-> (w0 == n_tot));
endmodule

// File: rtl/otsu_thresh_engine.sv
module otsu_thresh_engine #(
  parameter int LANES = 8,
  parameter int CNT_W = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*8-1:0] in_data,
  input  logic               in_last,
  output logic               thr_valid,
  output logic [7:0]         thr_value
);
  import otsu_pkg::*;

  localparam int SUM_W = CNT_W + PIX_W;
  localparam logic [BIN_AW-1:0] LAST_BIN = BIN_AW'(NBINS - 1);

  eng_state_e        state, state_d;
  logic [BIN_AW-1:0] sw_addr;
  logic              sweep_en, fire, start, in_ready_q;
  logic [CNT_W-1:0]  n_tot;
  logic [SUM_W-1:0]  m_tot, beat_sum;
  logic [CNT_W-1:0]  bin_q [LANES];
  logic [CNT_W-1:0]  bin_sum;

  // read-side pipeline tags and merged bin
  logic              rv1, rl1, hv, hlast;
  logic [BIN_AW-1:0] rt1, ht;
  logic [CNT_W-1:0]  hcnt;
  logic              res_valid;
  logic [BIN_AW-1:0] res_thr;

  assign in_ready = in_ready_q;
  assign fire     = in_valid & in_ready_q;
  assign sweep_en = (state == ST_CLEAR) || (state == ST_SWEEP);
  assign start    = (state == ST_DRAIN);

  genvar g;
  for (g = 0; g < LANES; g++) begin : g_lane
    otsu_hist_lane #(.CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .pix_valid (fire),
      .pix       (in_data[g*PIX_W +: PIX_W]),
      .sweep_en  (sweep_en),
      .sweep_addr(sw_addr),
      .bin_q     (bin_q[g])
    );
  end

  always_comb begin
    bin_sum  = '0;
    beat_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      bin_sum  = bin_sum + bin_q[i];
      beat_sum = beat_sum + SUM_W'(in_data[i*PIX_W +: PIX_W]);
    end
  end

  always_comb begin
    state_d = state;
    case (state)
      ST_CLEAR: if (sw_addr == LAST_BIN) state_d = ST_ACCUM;
      ST_ACCUM: if (fire && in_last)     state_d = ST_DRAIN;
      ST_DRAIN:                          state_d = ST_SWEEP;
      ST_SWEEP: if (sw_addr == LAST_BIN) state_d = ST_FLUSH;
      ST_FLUSH: if (res_valid)           state_d = ST_ACCUM;
      default:                           state_d = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      sw_addr    <= '0;
      in_ready_q <= 1'b0;
      thr_valid  <= 1'b0;
      thr_value  <= '0;
      n_tot      <= '0;
      m_tot      <= '0;
      rv1 <= 1'b0; rl1 <= 1'b0; rt1 <= '0;
      hv  <= 1'b0; hlast <= 1'b0; ht <= '0; hcnt <= '0;
    end else begin
      state      <= state_d;
      sw_addr    <= sweep_en ? BIN_AW'(sw_addr + 1'b1) : '0;
      in_ready_q <= (state_d == ST_ACCUM);
      thr_valid  <= (state == ST_FLUSH) && res_valid;
      if ((state == ST_FLUSH) && res_valid) begin
        thr_value <= res_thr;
        n_tot     <= '0;
        m_tot     <= '0;
      end else if (fire) begin
        n_tot <= n_tot + CNT_W'(LANES);
        m_tot <= m_tot + beat_sum;
      end
      rv1   <= (state == ST_SWEEP);
      rl1   <= (state == ST_SWEEP) && (sw_addr == LAST_BIN);
      rt1   <= sw_addr;
      hv    <= rv1;
      hlast <= rl1;
      ht    <= rt1;
      hcnt  <= bin_sum;
    end
  end

  otsu_score_sweep #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .hv       (hv),
    .hcnt     (hcnt),
    .ht       (ht),
    .hlast    (hlast),
    .n_tot    (n_tot),
    .m_tot    (m_tot),
    .res_valid(res_valid),
    .res_thr  (res_thr)
  );

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    thr_valid |=> !thr_valid);

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/otsu_thresh_engine_test.sv
module otsu_thresh_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        v8 = 1'b0, l8 = 1'b0;
  logic [63:0] d8 = '0;
  logic        r8, dn8;
  logic [7:0]  t8;
  logic        v1 = 1'b0, l1 = 1'b0;
  logic [7:0]  d1 = '0;
  logic        r1, dn1;
  logic [7:0]  t1;

  int checks = 0;
  int fails  = 0;

  otsu_thresh_engine #(.LANES(8)) uut (
    .clk(clk), .rst(rst), .in_valid(v8), .in_ready(r8), .in_data(d8),
    .in_last(l8), .thr_valid(dn8), .thr_value(t8));

  otsu_thresh_engine #(.LANES(1)) uut1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(r1), .in_data(d1),
    .in_last(l1), .thr_valid(dn1), .thr_value(t1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: exact score comparison in 64-bit integers
  function automatic int ref_thr(input int px[$]);
    longint h[256];
    longint n, s, c, m, num, den, bn, bd, d;
    int best, lowest;
    bit found;
    for (int i = 0; i < 256; i++) h[i] = 0;
    n = 0; s = 0;
    foreach (px[i]) begin h[px[i]]++; n++; s += px[i]; end
    c = 0; m = 0; found = 0; best = 0; lowest = -1; bn = 0; bd = 1;
    for (int t = 0; t < 256; t++) begin
      c += h[t];
      m += h[t] * t;
      if (lowest < 0 && h[t] != 0) lowest = t;
      if (c != 0 && c != n) begin
        d   = s * c - n * m;
        num = d * d;
        den = c * (n - c);
        if (!found || num * bd > bn * den) begin
          found = 1; bn = num; bd = den; best = t;
        end
      end
    end
    return found ? best : lowest;
  endfunction

  task automatic run8(input int px[$], input string req);
    int exp, b, beats, cyc;
    bit was, busy_ok;
    exp = ref_thr(px);
    beats = px.size() / 8;
    b = 0;
    while (b < beats) begin
      @(negedge clk);
      v8 = 1'b1;
      for (int k = 0; k < 8; k++) d8[k*8 +: 8] = 8'(px[b*8+k]);
      l8 = (b == beats - 1);
      was = r8;
      @(posedge clk);
      if (was) b++;
    end
    @(negedge clk);
    v8 = 1'b0; l8 = 1'b0;
    busy_ok = 1'b1; cyc = 0;
    while (!dn8 && cyc < 2000) begin
      if (r8) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(dn8, {req, " R3 done seen (8 lanes)"}, int'(dn8), 1);
    chk(busy_ok, "R3 ready low while busy (8 lanes)", int'(busy_ok), 1);
    chk(t8 == 8'(exp), {req, " threshold (8 lanes)"}, int'(t8), exp);
    chk(r8, "R2 ready back with result (8 lanes)", int'(r8), 1);
    @(negedge clk);
    chk(!dn8, "R3 done lasts one cycle (8 lanes)", int'(dn8), 0);
  endtask

  task automatic run1(input int px[$], input string req);
    int exp, b, cyc;
    bit was, busy_ok;
    exp = ref_thr(px);
    b = 0;
    while (b < px.size()) begin
      @(negedge clk);
      v1 = 1'b1;
      d1 = 8'(px[b]);
      l1 = (b == px.size() - 1);
      was = r1;
      @(posedge clk);
      if (was) b++;
    end
    @(negedge clk);
    v1 = 1'b0; l1 = 1'b0;
    busy_ok = 1'b1; cyc = 0;
    while (!dn1 && cyc < 2000) begin
      if (r1) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(dn1, {req, " R10 done seen (1 lane)"}, int'(dn1), 1);
    chk(busy_ok, "R10 R3 ready low while busy (1 lane)", int'(busy_ok), 1);
    chk(t1 == 8'(exp), {req, " R10 threshold (1 lane)"}, int'(t1), exp);
    @(negedge clk);
    chk(!dn1, "R10 done lasts one cycle (1 lane)", int'(dn1), 0);
  endtask

  task automatic run_both(input int px[$], input string req);
    run8(px, req);
    run1(px, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int q[$];
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!dn8 && !dn1, "R1 no result after reset", int'(dn8 | dn1), 0);
    chk(!r8 && !r1, "R1 ready low while clearing", int'(r8 | r1), 0);
    repeat (300) @(negedge clk);
    chk(r8 && r1, "R1 ready high after clearing", int'(r8 & r1), 1);

    // bimodal frame
    q = {};
    for (int i = 0; i < 64; i++) q.push_back((i % 2) ? 200 : 20);
    run_both(q, "R4 bimodal");

    // single gray level, identical values in every lane and beat
    q = {};
    for (int i = 0; i < 64; i++) q.push_back(77);
    run_both(q, "R7 R9 single level");

    // R8: new frame after a different one, result from new pixels only
    q = {};
    for (int i = 0; i < 32; i++) q.push_back(i < 8 ? 3 : 140 + (i % 5));
    run_both(q, "R8 fresh histogram");

    // R6: 0 and 255 in equal counts, all candidates 0..254 tie -> 0
    q = {};
    for (int i = 0; i < 16; i++) q.push_back((i < 8) ? 0 : 255);
    run_both(q, "R6 tie lowest");

    // R5: only t=10 splits the frame
    q = {};
    for (int i = 0; i < 16; i++) q.push_back((i % 4 == 0) ? 11 : 10);
    run_both(q, "R5 empty class skip");

    // ramp
    q = {};
    for (int i = 0; i < 64; i++) q.push_back(i * 4);
    run_both(q, "R4 ramp");

    // three clusters from a small pseudo-random sequence
    begin
      int r;
      r = 7;
      q = {};
      for (int i = 0; i < 64; i++) begin
        r = (r * 73 + 41) % 1021;
        q.push_back((i % 3 == 0) ? 40 + r % 10 : (i % 3 == 1) ? 120 + r % 12 : 220 + r % 9);
      end
    end
    run_both(q, "R4 three clusters");

    // R9: one beat, pairs of equal values
    q = {5, 5, 5, 5, 9, 9, 9, 9};
    run_both(q, "R9 one beat");

    // R9: same values repeated beat after beat, skewed counts
    q = {};
    for (int i = 0; i < 48; i++) q.push_back((i < 40) ? 60 : 61 + (i % 2) * 100);
    run_both(q, "R9 repeats");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule